// File: doc/BRIEF.md
# Two-Stage Interrupt-Then-Reset Watchdog

This block is a watchdog timer driven by one 12-bit control word. When its interval runs out, it first raises a pending flag and, if allowed, an interrupt. It then starts a grace period of a fixed 1024 prescaled ticks. If software has not restarted the watchdog by the end of that grace period and resets are allowed, the block sets a sticky reset flag. It also drives a system reset level, which stays high until a power-on reset.

The reference clock is the block clock. A selectable prescaler divides it by 1, 256, 2048 or 65536. The interval is 2^(BASE_SHIFT + 2 x interval select) prescaled ticks. Software controls the timer by writing the whole control word:
- It can start and pause the counter. A pause keeps the remaining count.
- A self-clearing restart bit reloads the interval.
- The two flags are cleared by writing one to them.

A separate debug-halt input freezes counting when the freeze bit is set. Two resets reach the block:
- A core reset returns the control word to its default but keeps the reset flag and the reset output.
- A power-on reset clears everything.

Top module: `stage_wdog`

## Requirements
- R1: After power-on reset the control word reads 0x400, irq_o is 0 and sys_rst_o is 0.
- R2: Control word fields are [11:10] clock select, [9] freeze enable, [7] enable, [6] interrupt enable, [5:4] interval select, [3] interrupt flag, [2] reset flag, [1] reset enable and [0] restart. Bits 0 and 8 always read 0.
- R3: A write with restart set loads 2^(BASE_SHIFT+2*isel) prescaled ticks. With enable set and clock select 0, the interrupt flag sets exactly that many clocks after the write edge.
- R4: irq_o is high exactly when the interrupt flag and the interrupt enable are both 1.
- R5: After the first expiry, 1024 further prescaled ticks elapse. If reset enable is set at that point, the reset flag and sys_rst_o become 1 on the same edge.
- R6: An expiry with the interrupt flag already set and reset enable clear changes nothing, and the counter stays idle.
- R7: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 leaves it unchanged.
- R8: A restart while the interrupt flag is set abandons the grace period. The next expiry then goes straight to the reset stage.
- R9: Clearing enable without restart pauses the count. Setting it again resumes from the remaining count.
- R10: Clock select 1 and 2 divide the tick rate by 256 and 2048.
- R11: A core reset sets the control word to 0x400 but keeps the reset flag and the sys_rst_o level.
- R12: sys_rst_o, once high, stays high until power-on reset, which also clears the reset flag.
- R13: While freeze enable is set and dbg_halt is high, counting stops.
- R14: After a core reset the counter holds 2^BASE_SHIFT, so enabling without restart expires after that many ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock and reference tick |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| dbg_halt | input | 1 | Debug halt request, gates counting when freeze is enabled |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 12 | Control word write value |
| ctrl_rd | output | 12 | Current control word |
| irq_o | output | 1 | Interrupt level |
| sys_rst_o | output | 1 | System reset level |

## Verification
The bench aims at the exact expiry edge for several interval and prescaler settings. A counter that is off by one, or a prescaler that does not restart on reload, would move the flag by a clock or a whole prescaled tick.

Other cases target the flag state at expiry:
- a second expiry with reset enable clear, where a wrong design would assert reset;
- a restart while the flag is set, where a wrong design would give a second interrupt instead of a reset;
- a write of zero to a flag, which a wrong design would clear.

Reset-domain cases check that a core reset keeps the reset flag and the output level, and that a power-on reset clears them. They also check that a pause keeps the count, and that freeze stops the count only while halt is high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CTRL_W      = 12;
    localparam int B_CLKSEL    = 10;
    localparam int B_FRZ       = 9;
    localparam int B_EN        = 7;
    localparam int B_IE        = 6;
    localparam int B_ISEL      = 4;
    localparam int B_IF        = 3;
    localparam int B_RF        = 2;
    localparam int B_RE        = 1;
    localparam int B_RESTART   = 0;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       frz;
        logic       en;
        logic       ie;
        logic [1:0] isel;
        logic       iflag;
        logic       re;
    } core_regs_t;

    typedef struct packed {
        logic rflag;
        logic rst_out;
    } sticky_regs_t;

    localparam core_regs_t CORE_RST = '{clk_sel: 2'd1, default: '0};

    // log2 of the prescaler division for each clock select code
    function automatic int div_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 8;
            2'd2:    return 11;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PS_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);
    import wdog_pkg::*;

    logic [PS_W-1:0] pre_d, pre_q;
    logic [PS_W:0]   lim;

    always_comb begin
        lim  = ((PS_W+1)'(1) << div_shift(sel)) - (PS_W+1)'(1);
        tick = run && ({1'b0, pre_q} >= lim);
        pre_d = pre_q;
        if (clear) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = tick ? '0 : pre_q + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int               CNT_W   = 21,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && (cnt_q == CNT_W'(1));
        cnt_d  = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl #(
    parameter int BASE_SHIFT = 14,
    parameter int GRACE      = 1024,
    parameter int CNT_W      = 21
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       rst_n,
    input  logic                       core_rst_n,
    input  logic                       dbg_halt,
    input  logic                       wr_en,
    input  logic [wdog_pkg::CTRL_W-1:0] wr_data,
    input  logic                       expire,
    output logic                       run,
    output logic [1:0]                 clk_sel,
    output logic                       load,
    output logic [CNT_W-1:0]           load_val,
    output logic [wdog_pkg::CTRL_W-1:0] ctrl_rd,
    output logic                       irq_o,
    output logic                       sys_rst_o
);
    import wdog_pkg::*;

    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE);

    core_regs_t   core_d, core_q;
    sticky_regs_t st_d, st_q;
    logic         wr_ok, restart;
    logic         unused_rsvd;

    assign unused_rsvd = wr_data[8];

    always_comb begin
        core_d   = core_q;
        st_d     = st_q;
        load     = 1'b0;
        load_val = '0;
        wr_ok    = wr_en && rst_n;
        restart  = wr_ok && wr_data[B_RESTART];

        if (wr_ok) begin
            core_d.clk_sel = wr_data[B_CLKSEL +: 2];
            core_d.frz     = wr_data[B_FRZ];
            core_d.en      = wr_data[B_EN];
            core_d.ie      = wr_data[B_IE];
            core_d.isel    = wr_data[B_ISEL +: 2];
            core_d.re      = wr_data[B_RE];
            core_d.iflag   = core_q.iflag & ~wr_data[B_IF];
            st_d.rflag     = st_q.rflag   & ~wr_data[B_RF];
        end

        // expiry is judged on the state before this cycle's write
        if (restart) begin
            load     = 1'b1;
            load_val = ONE << (BASE_SHIFT + 2 * int'(core_d.isel));
        end else if (expire) begin
            if (!core_q.iflag) begin
                core_d.iflag = 1'b1;
                load         = 1'b1;
                load_val     = GRACE_CNT;
            end else if (core_q.re) begin
                st_d.rflag   = 1'b1;
                st_d.rst_out = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) core_q <= CORE_RST;
        else             core_q <= core_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run       = core_q.en && !(core_q.frz && dbg_halt);
    assign clk_sel   = core_q.clk_sel;
    assign irq_o     = core_q.iflag && core_q.ie;
    assign sys_rst_o = st_q.rst_out;
    assign ctrl_rd   = {core_q.clk_sel, core_q.frz, 1'b0, core_q.en, core_q.ie,
                        core_q.isel, core_q.iflag, st_q.rflag, core_q.re, 1'b0};

endmodule

// File: rtl/stage_wdog.sv
module stage_wdog #(
    parameter int BASE_SHIFT = 14,
    parameter int GRACE      = 1024,
    parameter int PS_W       = 16
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        dbg_halt,
    input  logic        wr_en,
    input  logic [11:0] wr_data,
    output logic [11:0] ctrl_rd,
    output logic        irq_o,
    output logic        sys_rst_o
);
    localparam int CNT_W = (BASE_SHIFT + 7 > 12) ? BASE_SHIFT + 7 : 12;
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1) << BASE_SHIFT;

    logic             core_rst_n;
    logic             run, tick, load, expire;
    logic [1:0]       clk_sel;
    logic [CNT_W-1:0] load_val;

    assign core_rst_n = por_n & rst_n;

    wdog_prescale #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (core_rst_n),
        .run   (run),
        .clear (load),
        .sel   (clk_sel),
        .tick  (tick)
    );

    wdog_count #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

    wdog_ctl #(.BASE_SHIFT(BASE_SHIFT), .GRACE(GRACE), .CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .dbg_halt   (dbg_halt),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .expire     (expire),
        .run        (run),
        .clk_sel    (clk_sel),
        .load       (load),
        .load_val   (load_val),
        .ctrl_rd    (ctrl_rd),
        .irq_o      (irq_o),
        .sys_rst_o  (sys_rst_o)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        wr_en,
    input logic [11:0] wr_data,
    input logic [11:0] ctrl_rd,
    input logic        irq_o,
    input logic        sys_rst_o
);
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_rd[0] == 1'b0) && (ctrl_rd[8] == 1'b0)); // R2

    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
        irq_o |-> (ctrl_rd[3] && ctrl_rd[6])); // R4

    AST_RST_WITH_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_o) |-> ctrl_rd[2]); // R5

    AST_IFLAG_HOLD: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (ctrl_rd[3] && !(wr_en && wr_data[3])) |=> ctrl_rd[3]); // R7

    AST_PAUSED_NO_EXPIRY: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (!ctrl_rd[7] && !ctrl_rd[3] && !wr_en) |=> !ctrl_rd[3]); // R9

    AST_RFLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_rd[2] && !(wr_en && wr_data[2])) |=> ctrl_rd[2]); // R11

    AST_RST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_o |=> sys_rst_o); // R12

endmodule

bind stage_wdog wdog_checker u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ctrl_rd   (ctrl_rd),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o)
);

// File: tb/tb_stage_wdog.sv
module tb_stage_wdog;
    localparam int BS = 4;
    localparam int GR = 1024;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, dbg_halt = 1'b0, wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] ctrl_rd;
    logic        irq_o, sys_rst_o;
    int          n_chk = 0, n_fail = 0;
    bit          cmp_on = 1'b0;

    always #10 clk = ~clk;

    stage_wdog #(.BASE_SHIFT(BS), .GRACE(GR)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cs, m_frz, m_en, m_ie, m_is, m_if, m_re, m_rf, m_ro, m_cnt, m_pre;

    function automatic int shift_of(input int cs);
        if (cs == 0) return 0;
        if (cs == 1) return 8;
        if (cs == 2) return 11;
        return 16;
    endfunction

    function automatic int m_word();
        return (m_cs << 10) | (m_frz << 9) | (m_en << 7) | (m_ie << 6) |
               (m_is << 4) | (m_if << 3) | (m_rf << 2) | (m_re << 1);
    endfunction

    always @(posedge clk) begin
        int  div, ncnt, npre, old_if, old_re;
        bit  run, tick, ev;
        if (!por_n || !rst_n) begin
            m_cs = 1; m_frz = 0; m_en = 0; m_ie = 0; m_is = 0; m_if = 0; m_re = 0;
            m_cnt = 1 << BS; m_pre = 0;
            if (!por_n) begin m_rf = 0; m_ro = 0; end
        end else begin
            div    = 1 << shift_of(m_cs);
            run    = (m_en != 0) && !((m_frz != 0) && dbg_halt);
            tick   = run && (m_pre >= div - 1);
            ev     = tick && (m_cnt == 1);
            ncnt   = m_cnt;
            npre   = m_pre;
            old_if = m_if;
            old_re = m_re;
            if (run) npre = tick ? 0 : m_pre + 1;
            if (tick && m_cnt > 0) ncnt = m_cnt - 1;
            if (wr_en) begin
                m_cs = wr_data[11:10]; m_frz = wr_data[9]; m_en = wr_data[7];
                m_ie = wr_data[6]; m_is = wr_data[5:4]; m_re = wr_data[1];
                if (wr_data[3]) m_if = 0;
                if (wr_data[2]) m_rf = 0;
            end
            if (wr_en && wr_data[0]) begin
                ncnt = 1 << (BS + 2 * m_is);
                npre = 0;
            end else if (ev) begin
                if (old_if == 0) begin
                    m_if = 1; ncnt = GR; npre = 0;
                end else if (old_re != 0) begin
                    m_rf = 1; m_ro = 1;
                end
            end
            m_cnt = ncnt;
            m_pre = npre;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3/R5 model ctrl", 32'(ctrl_rd), 32'(m_word()));
            chk("R4 model irq", 32'(irq_o), 32'((m_if != 0) && (m_ie != 0)));
            chk("R12 model sys_rst", 32'(sys_rst_o), 32'(m_ro));
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [11:0] d);
        wr_en = 1'b1;
        wr_data = d;
        waitn(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        waitn(3);
        por_n = 1'b1;
        rst_n = 1'b1;
        waitn(1);
        cmp_on = 1'b1;
        chk("R1 ctrl", 32'(ctrl_rd), 32'h400);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 sys_rst", 32'(sys_rst_o), 0);

        // R2 field layout, bit 0 and bit 8 read zero
        wr(12'hEF2);
        chk("R2 readback", 32'(ctrl_rd), 32'hEF2);
        wr(12'hFF3);
        chk("R2 restart and bit8 read 0", 32'(ctrl_rd), 32'hEF2);
        wr(12'h000);

        // R3 R4 R7 R5: interval 2^(4+2)=64, then 1024 grace
        wr(12'h0D3);
        waitn(63);
        chk("R3 flag before timeout", 32'(ctrl_rd[3]), 0);
        waitn(1);
        chk("R3 flag at timeout", 32'(ctrl_rd[3]), 1);
        chk("R4 irq at timeout", 32'(irq_o), 1);
        wr(12'h0D2);
        chk("R7 write zero keeps flag", 32'(ctrl_rd[3]), 1);
        waitn(1022);
        chk("R5 no reset before grace end", 32'(sys_rst_o), 0);
        waitn(1);
        chk("R5 reset at grace end", 32'(sys_rst_o), 1);
        chk("R5 reset flag", 32'(ctrl_rd[2]), 1);
        wr(12'h0DA);
        chk("R7 write one clears flag", 32'(ctrl_rd[3]), 0);
        chk("R4 irq drops with flag", 32'(irq_o), 0);

        // R11 core reset keeps reset flag and level
        rst_n = 1'b0;
        waitn(2);
        rst_n = 1'b1;
        chk("R11 ctrl after core reset", 32'(ctrl_rd), 32'h404);
        chk("R11 sys_rst kept", 32'(sys_rst_o), 1);
        // R14 count after core reset is 2^4
        wr(12'h080);
        waitn(15);
        chk("R14 flag before 16 ticks", 32'(ctrl_rd[3]), 0);
        waitn(1);
        chk("R14 flag after 16 ticks", 32'(ctrl_rd[3]), 1);

        // R12 power-on reset clears everything
        por_n = 1'b0;
        waitn(2);
        por_n = 1'b1;
        chk("R12 ctrl after por", 32'(ctrl_rd), 32'h400);
        chk("R12 sys_rst cleared", 32'(sys_rst_o), 0);

        // R6 second expiry without reset enable
        wr(12'h0D1);
        waitn(64);
        chk("R6 first expiry", 32'(ctrl_rd[3]), 1);
        waitn(GR + 50);
        chk("R6 no reset", 32'(sys_rst_o), 0);
        chk("R6 no reset flag", 32'(ctrl_rd[2]), 0);

        // R8 restart while flag set goes to reset stage
        wr(12'h0D3);
        waitn(63);
        chk("R8 no reset before interval", 32'(sys_rst_o), 0);
        waitn(1);
        chk("R8 reset after interval", 32'(sys_rst_o), 1);
        por_n = 1'b0;
        waitn(2);
        por_n = 1'b1;

        // R9 pause keeps remaining count
        wr(12'h0D1);
        waitn(20);
        wr(12'h050);
        waitn(100);
        chk("R9 no expiry while paused", 32'(ctrl_rd[3]), 0);
        wr(12'h0D0);
        waitn(42);
        chk("R9 remaining count not done", 32'(ctrl_rd[3]), 0);
        waitn(1);
        chk("R9 resumed count expires", 32'(ctrl_rd[3]), 1);
        wr(12'h008);

        // R13 freeze with debug halt
        dbg_halt = 1'b1;
        wr(12'h2D1);
        waitn(200);
        chk("R13 frozen", 32'(ctrl_rd[3]), 0);
        dbg_halt = 1'b0;
        waitn(63);
        chk("R13 counting after halt", 32'(ctrl_rd[3]), 0);
        waitn(1);
        chk("R13 expiry after halt", 32'(ctrl_rd[3]), 1);
        wr(12'h008);

        // R10 prescaler 256 and 2048
        wr(12'h4C1);
        waitn(16 * 256 - 1);
        chk("R10 div256 before", 32'(ctrl_rd[3]), 0);
        waitn(1);
        chk("R10 div256 at", 32'(ctrl_rd[3]), 1);
        wr(12'h808);
        wr(12'h8C1);
        waitn(16 * 2048 - 1);
        chk("R10 div2048 before", 32'(ctrl_rd[3]), 0);
        waitn(1);
        chk("R10 div2048 at", 32'(ctrl_rd[3]), 1);

        waitn(2);
        finish_run();
    end

endmodule